// File: doc/BRIEF.md
# DMA Channel Register Block

This block holds the software-visible register set of one channel of a descriptor-chained copy engine. A host reaches it through a simple memory-mapped request port. Each request carries a byte offset, an access size of 1, 2, 4 or 8 bytes, a direction and write data. Every request is answered one cycle later with a response strobe and, for reads, the read data. An access whose size does not fit the addressed register, or that hits an unmapped offset, is refused and flagged on the response.

The block stores the channel's control word, its command byte, its error bits and two 64-bit addresses: the head of the descriptor chain and the completion write-back address. Either address can be written whole with one 8-byte access. It can also be written as two 4-byte halves, and each half leaves the other untouched. Some accesses have side effects:
- reading the control word marks the channel as claimed;
- writing the command byte sends a one-cycle strobe to the channel datapath;
- the error bits are cleared by writing ones to them.

The status word comes from the datapath. Its bit 0 is replaced with the inverse of the datapath's busy signal.

Top module: `dmachan_regs`

## Requirements
- R1: A 2-byte read at offset 0x00 returns the control word as it was before the read. On the following cycle, bit 8 (claimed) of the control word is 1.
- R2: A 2-byte write at offset 0x00 stores the written value. The exception is bit 0 (interrupt disable): writing 1 to it leaves it 0, and writing 0 to it keeps its previous value. The control word resets to 0x0001.
- R3: An 8-byte read at offset 0x08 returns status_i with bit 0 replaced by 1 when busy_i is low and by 0 when busy_i is high.
- R4: The chain address at offset 0x10 takes an 8-byte write of all 64 bits. A 4-byte write at 0x10 replaces bits 31:0 and keeps bits 63:32. A 4-byte write at 0x14 replaces bits 63:32 and keeps bits 31:0.
- R5: The completion address at offsets 0x20 and 0x24 follows the same full, low-half and high-half write rules as the chain address.
- R6: An 8-byte read of either address returns all 64 bits. A 4-byte read at the low offset returns bits 31:0, and a 4-byte read at the high offset returns bits 63:32, each zero-extended.
- R7: A 1-byte write at offset 0x18 stores the command byte. cmd_strobe_o is high for exactly the one cycle after the write is accepted. A 1-byte read at 0x18 returns the stored byte.
- R8: A 4-byte write at offset 0x28 clears every error bit where the data holds a 1 and keeps the rest. Bits raised on err_set_i are ORed in, and a bit raised in the same cycle as its clear stays set.
- R9: An access of the wrong size, a write to the status word, or any unmapped offset raises rsp_err. Such an access changes no register, raises no command strobe and returns read data 0.
- R10: Every request is answered with rsp_valid exactly one cycle later. After reset the addresses, command and error bits are 0.

Size encoding on req_size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the channel |
| req_size | input | 2 | Access size code |
| req_wdata | input | 64 | Write data, right-aligned |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 64 | Read data, zero-extended |
| rsp_err | output | 1 | Previous request was refused |
| busy_i | input | 1 | Channel datapath busy |
| status_i | input | 64 | Status word from the datapath |
| err_set_i | input | 32 | Error bits raised by the datapath |
| ctrl_o | output | 16 | Current control word |
| chain_addr_o | output | 64 | Descriptor chain address |
| cmpl_addr_o | output | 64 | Completion address |
| command_o | output | 8 | Current command byte |
| error_o | output | 32 | Current error bits |
| cmd_strobe_o | output | 1 | Command written (one cycle) |

## Verification
All stored state is visible on the output ports, so most internal faults show at the ports within one cycle of the access that exposes them. A half-write that disturbs the other half shows on the address port right after the write. The same holds for a claimed bit that is not set, or an interrupt-disable bit that survives a write of 1. A fault in the read path shows on the response one cycle after the read. A lost or doubled command strobe shows in the two cycles after the command write. A refused access that still changes a register shows on that register's output port in the cycle its error response appears.

// File: rtl/dmachan_pkg.sv
package dmachan_pkg;

    typedef enum logic [1:0] {
        SZ_B1 = 2'd0,
        SZ_B2 = 2'd1,
        SZ_B4 = 2'd2,
        SZ_B8 = 2'd3
    } acc_size_e;

    typedef enum logic [3:0] {
        T_NONE,
        T_CTRL,
        T_STAT,
        T_CHAIN,
        T_CHAIN_HI,
        T_CMD,
        T_CMPL,
        T_CMPL_HI,
        T_ERR
    } target_e;

    localparam int OFS_CTRL     = 'h00;
    localparam int OFS_STAT     = 'h08;
    localparam int OFS_CHAIN    = 'h10;
    localparam int OFS_CHAIN_HI = 'h14;
    localparam int OFS_CMD      = 'h18;
    localparam int OFS_CMPL     = 'h20;
    localparam int OFS_CMPL_HI  = 'h24;
    localparam int OFS_ERR      = 'h28;

    localparam int CTRL_INTDIS_BIT = 0;
    localparam int CTRL_CLAIM_BIT  = 8;

    typedef struct packed {
        logic      ok;
        target_e   tgt;
    } dec_t;

    function automatic logic size_legal(target_e t, logic wr, acc_size_e sz);
        case (t)
            T_CTRL:               return sz == SZ_B2;
            T_STAT:               return !wr && sz == SZ_B8;
            T_CHAIN, T_CMPL:      return sz == SZ_B8 || sz == SZ_B4;
            T_CHAIN_HI, T_CMPL_HI: return sz == SZ_B4;
            T_CMD:                return sz == SZ_B1;
            T_ERR:                return sz == SZ_B4;
            default:              return 1'b0;
        endcase
    endfunction

    function automatic logic [63:0] addr_view(logic [63:0] a, logic hi, logic full);
        if (full)    return a;
        else if (hi) return {32'h0, a[63:32]};
        else         return {32'h0, a[31:0]};
    endfunction

endpackage

// File: rtl/dmachan_decode.sv
module dmachan_decode
    import dmachan_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output dec_t              dec
);
    target_e t;

    always_comb begin
        case (addr)
            ADDR_W'(OFS_CTRL):     t = T_CTRL;
            ADDR_W'(OFS_STAT):     t = T_STAT;
            ADDR_W'(OFS_CHAIN):    t = T_CHAIN;
            ADDR_W'(OFS_CHAIN_HI): t = T_CHAIN_HI;
            ADDR_W'(OFS_CMD):      t = T_CMD;
            ADDR_W'(OFS_CMPL):     t = T_CMPL;
            ADDR_W'(OFS_CMPL_HI):  t = T_CMPL_HI;
            ADDR_W'(OFS_ERR):      t = T_ERR;
            default:               t = T_NONE;
        endcase
        dec.tgt = t;
        dec.ok  = size_legal(t, write, acc_size_e'(size));
    end

    // R9: an unmapped offset is never accepted
    always_comb begin
        assert_unmapped_refused_R9: assert (!(dec.tgt == T_NONE && dec.ok));
    end
endmodule

// File: rtl/dmachan_addr64.sv
module dmachan_addr64 #(
    parameter logic [63:0] RST_VAL = 64'h0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_full,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [63:0] wdata,
    output logic [63:0] q
);
    always_ff @(posedge clk) begin
        if (rst)          q <= RST_VAL;
        else if (wr_full) q <= wdata;
        else if (wr_lo)   q <= {q[63:32], wdata[31:0]};
        else if (wr_hi)   q <= {wdata[31:0], q[31:0]};
    end

    assert_lo_keeps_hi_R4: assert property (@(posedge clk) disable iff (rst)
        wr_lo && !wr_full |=> q[63:32] == $past(q[63:32]));
    assert_hi_keeps_lo_R4: assert property (@(posedge clk) disable iff (rst)
        wr_hi && !wr_full && !wr_lo |=> q[31:0] == $past(q[31:0]));
endmodule

// File: rtl/dmachan_ctrl.sv
module dmachan_ctrl
    import dmachan_pkg::*;
#(
    parameter logic [15:0] CTRL_RST = 16'h0001,
    parameter int          ERR_W    = 32,
    parameter int          CMD_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ctrl,
    input  logic             rd_ctrl,
    input  logic             wr_cmd,
    input  logic             wr_err,
    input  logic [15:0]      wdata_ctrl,
    input  logic [CMD_W-1:0] wdata_cmd,
    input  logic [ERR_W-1:0] wdata_err,
    input  logic [ERR_W-1:0] err_set,
    output logic [15:0]      ctrl_q,
    output logic [CMD_W-1:0] cmd_q,
    output logic [ERR_W-1:0] err_q,
    output logic             strobe
);
    logic [15:0] ctrl_next;

    always_comb begin
        ctrl_next = wdata_ctrl;
        ctrl_next[CTRL_INTDIS_BIT] = wdata_ctrl[CTRL_INTDIS_BIT] ? 1'b0
                                                                 : ctrl_q[CTRL_INTDIS_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
        end else if (wr_ctrl) begin
            ctrl_q <= ctrl_next;
        end else if (rd_ctrl) begin
            ctrl_q[CTRL_CLAIM_BIT] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= wr_cmd;
            if (wr_cmd) cmd_q <= wdata_cmd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         err_q <= '0;
        else if (wr_err) err_q <= (err_q & ~wdata_err) | err_set;
        else             err_q <= err_q | err_set;
    end

    assert_claim_after_read_R1: assert property (@(posedge clk) disable iff (rst)
        rd_ctrl && !wr_ctrl |=> ctrl_q[CTRL_CLAIM_BIT]);
    assert_intdis_cleared_R2: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl && wdata_ctrl[CTRL_INTDIS_BIT] |=> !ctrl_q[CTRL_INTDIS_BIT]);
    assert_strobe_follows_write_R7: assert property (@(posedge clk) disable iff (rst)
        strobe |-> $past(wr_cmd));
    assert_w1c_R8: assert property (@(posedge clk) disable iff (rst)
        wr_err |=> (err_q & $past(wdata_err) & ~$past(err_set)) == '0);
endmodule

// File: rtl/dmachan_regs.sv
module dmachan_regs
    import dmachan_pkg::*;
#(
    parameter int          ADDR_W   = 6,
    parameter logic [15:0] CTRL_RST = 16'h0001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    output logic              rsp_err,
    input  logic              busy_i,
    input  logic [63:0]       status_i,
    input  logic [31:0]       err_set_i,
    output logic [15:0]       ctrl_o,
    output logic [63:0]       chain_addr_o,
    output logic [63:0]       cmpl_addr_o,
    output logic [7:0]        command_o,
    output logic [31:0]       error_o,
    output logic              cmd_strobe_o
);
    localparam int N_ADDR = 2;

    dec_t dec;
    logic acc_wr, acc_rd, full_sz;
    logic [N_ADDR-1:0] sel_lo, sel_hi, w_full, w_lo, w_hi;
    logic [63:0] addr_q [N_ADDR];
    logic [63:0] rd_val;

    dmachan_decode #(.ADDR_W(ADDR_W)) u_dec (
        .write (req_write),
        .addr  (req_addr),
        .size  (req_size),
        .dec   (dec)
    );

    assign acc_wr  = req_valid && dec.ok && req_write;
    assign acc_rd  = req_valid && dec.ok && !req_write;
    assign full_sz = acc_size_e'(req_size) == SZ_B8;

    assign sel_lo = {dec.tgt == T_CMPL,    dec.tgt == T_CHAIN};
    assign sel_hi = {dec.tgt == T_CMPL_HI, dec.tgt == T_CHAIN_HI};

    for (genvar i = 0; i < N_ADDR; i++) begin : g_addr
        assign w_full[i] = acc_wr && sel_lo[i] && full_sz;
        assign w_lo[i]   = acc_wr && sel_lo[i] && !full_sz;
        assign w_hi[i]   = acc_wr && sel_hi[i];
        dmachan_addr64 u_reg (
            .clk     (clk),
            .rst     (rst),
            .wr_full (w_full[i]),
            .wr_lo   (w_lo[i]),
            .wr_hi   (w_hi[i]),
            .wdata   (req_wdata),
            .q       (addr_q[i])
        );
    end

    assign chain_addr_o = addr_q[0];
    assign cmpl_addr_o  = addr_q[1];

    dmachan_ctrl #(.CTRL_RST(CTRL_RST), .ERR_W(32), .CMD_W(8)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_ctrl    (acc_wr && dec.tgt == T_CTRL),
        .rd_ctrl    (acc_rd && dec.tgt == T_CTRL),
        .wr_cmd     (acc_wr && dec.tgt == T_CMD),
        .wr_err     (acc_wr && dec.tgt == T_ERR),
        .wdata_ctrl (req_wdata[15:0]),
        .wdata_cmd  (req_wdata[7:0]),
        .wdata_err  (req_wdata[31:0]),
        .err_set    (err_set_i),
        .ctrl_q     (ctrl_o),
        .cmd_q      (command_o),
        .err_q      (error_o),
        .strobe     (cmd_strobe_o)
    );

    always_comb begin
        case (dec.tgt)
            T_CTRL:     rd_val = {48'h0, ctrl_o};
            T_STAT:     rd_val = (status_i & ~64'h1) | {63'h0, ~busy_i};
            T_CHAIN:    rd_val = addr_view(addr_q[0], 1'b0, full_sz);
            T_CHAIN_HI: rd_val = addr_view(addr_q[0], 1'b1, 1'b0);
            T_CMD:      rd_val = {56'h0, command_o};
            T_CMPL:     rd_val = addr_view(addr_q[1], 1'b0, full_sz);
            T_CMPL_HI:  rd_val = addr_view(addr_q[1], 1'b1, 1'b0);
            T_ERR:      rd_val = {32'h0, error_o};
            default:    rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && !dec.ok;
            rsp_rdata <= acc_rd ? rd_val : '0;
        end
    end

    assert_status_busy_bit_R3: assert property (@(posedge clk) disable iff (rst)
        $past(acc_rd) && $past(dec.tgt) == T_STAT |-> rsp_rdata[0] == !$past(busy_i));
    assert_refused_no_change_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> $stable(chain_addr_o) && $stable(cmpl_addr_o) &&
                    $stable(ctrl_o) && $stable(command_o) && !cmd_strobe_o);
    assert_refused_zero_data_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_rdata == '0);
    assert_response_timing_R10: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    assert_err_implies_valid_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_valid);
endmodule

// File: tb/test_dmachan_regs.sv
`timescale 1ns/1ps
module test_dmachan_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [63:0] rsp_rdata;
    logic        busy_i = 1'b0;
    logic [63:0] status_i = '0;
    logic [31:0] err_set_i = '0;
    logic [15:0] ctrl_o;
    logic [63:0] chain_addr_o, cmpl_addr_o;
    logic [7:0]  command_o;
    logic [31:0] error_o;
    logic        cmd_strobe_o;

    int checks = 0;
    int errors = 0;
    logic        s_valid, s_err, s_strobe;
    logic [63:0] s_data;

    always #4 clk = ~clk;

    dmachan_regs i_dmachan_regs (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .busy_i(busy_i), .status_i(status_i), .err_set_i(err_set_i),
        .ctrl_o(ctrl_o), .chain_addr_o(chain_addr_o), .cmpl_addr_o(cmpl_addr_o),
        .command_o(command_o), .error_o(error_o), .cmd_strobe_o(cmd_strobe_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one request, response sampled on the following negedge
    task automatic access(input logic wr, input logic [5:0] a, input logic [1:0] sz,
                          input logic [63:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
        s_valid = rsp_valid; s_err = rsp_err; s_data = rsp_rdata; s_strobe = cmd_strobe_o;
    endtask

    task automatic t_reset();
        chk("R2 ctrl reset", ctrl_o, 64'h1);
        chk("R10 chain reset", chain_addr_o, 0);
        chk("R10 cmpl reset", cmpl_addr_o, 0);
        chk("R10 cmd/err reset", {command_o, error_o}, 0);
        chk("R10 no rsp at reset", {rsp_valid, cmd_strobe_o}, 0);
    endtask

    task automatic t_ctrl();
        access(1'b1, 6'h00, 2'd1, 64'h00A4);
        chk("R2 intdis kept when 0 written", ctrl_o, 64'h00A5);
        chk("R10 rsp_valid on write", {s_valid, s_err}, 2'b10);
        access(1'b1, 6'h00, 2'd1, 64'h00F1);
        chk("R2 intdis cleared when 1 written", ctrl_o, 64'h00F0);
        access(1'b0, 6'h00, 2'd1, 0);
        chk("R1 ctrl read returns old value", s_data, 64'h00F0);
        chk("R1 claim bit set after read", ctrl_o, 64'h01F0);
    endtask

    task automatic t_status();
        status_i = 64'hDEAD_BEEF_0000_1230; busy_i = 1'b0;
        access(1'b0, 6'h08, 2'd3, 0);
        chk("R3 status idle", s_data, 64'hDEAD_BEEF_0000_1231);
        status_i = 64'h8000_0000_0000_0001; busy_i = 1'b1;
        access(1'b0, 6'h08, 2'd3, 0);
        chk("R3 status busy", s_data, 64'h8000_0000_0000_0000);
        busy_i = 1'b0;
    endtask

    task automatic t_addr(input logic [5:0] base, input string tag, input bit is_chain);
        access(1'b1, base, 2'd3, 64'h1111_2222_3333_4444);
        chk({tag, " full write"}, is_chain ? chain_addr_o : cmpl_addr_o, 64'h1111_2222_3333_4444);
        access(1'b1, base, 2'd2, 64'hFFFF_FFFF_AAAA_BBBB);
        chk({tag, " low half write"}, is_chain ? chain_addr_o : cmpl_addr_o, 64'h1111_2222_AAAA_BBBB);
        access(1'b1, base + 6'h4, 2'd2, 64'h0000_0000_CCCC_DDDD);
        chk({tag, " high half write"}, is_chain ? chain_addr_o : cmpl_addr_o, 64'hCCCC_DDDD_AAAA_BBBB);
        access(1'b0, base, 2'd3, 0);
        chk("R6 full read", s_data, 64'hCCCC_DDDD_AAAA_BBBB);
        access(1'b0, base, 2'd2, 0);
        chk("R6 low read", s_data, 64'h0000_0000_AAAA_BBBB);
        access(1'b0, base + 6'h4, 2'd2, 0);
        chk("R6 high read", s_data, 64'h0000_0000_CCCC_DDDD);
    endtask

    task automatic t_command();
        access(1'b1, 6'h18, 2'd0, 64'h5A);
        chk("R7 strobe one cycle after write", s_strobe, 1);
        chk("R7 command stored", command_o, 64'h5A);
        @(negedge clk);
        chk("R7 strobe lasts one cycle", cmd_strobe_o, 0);
        access(1'b0, 6'h18, 2'd0, 0);
        chk("R7 command read", {s_strobe, s_data}, {1'b0, 64'h5A});
    endtask

    task automatic t_error();
        @(negedge clk); err_set_i = 32'h0000_00F3;
        @(negedge clk); err_set_i = '0;
        chk("R8 errors raised", error_o, 64'hF3);
        access(1'b1, 6'h28, 2'd2, 64'h0000_0031);
        chk("R8 w1c clears ones only", error_o, 64'hC2);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 6'h28; req_size = 2'd2;
        req_wdata = 64'h0000_0042; err_set_i = 32'h0000_0040;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; err_set_i = '0;
        chk("R8 set wins over clear", error_o, 64'hC0);
        access(1'b0, 6'h28, 2'd2, 0);
        chk("R8 error read", s_data, 64'hC0);
    endtask

    task automatic t_bad();
        access(1'b1, 6'h10, 2'd1, 64'h9999);
        chk("R9 bad size write flagged", {s_valid, s_err}, 2'b11);
        chk("R9 bad size no change", chain_addr_o, 64'hCCCC_DDDD_AAAA_BBBB);
        access(1'b1, 6'h14, 2'd3, 64'h7777_7777_7777_7777);
        chk("R9 8-byte high write refused", {s_err, chain_addr_o}, {1'b1, 64'hCCCC_DDDD_AAAA_BBBB});
        access(1'b0, 6'h00, 2'd2, 0);
        chk("R9 bad ctrl read data 0", {s_err, s_data}, {1'b1, 64'h0});
        access(1'b1, 6'h00, 2'd1, 64'h0000);
        access(1'b0, 6'h00, 2'd0, 0);
        chk("R9 bad ctrl read no claim", ctrl_o, 64'h0);
        access(1'b1, 6'h18, 2'd2, 64'h11);
        chk("R9 bad cmd write no strobe", {s_err, s_strobe, command_o}, {2'b10, 8'h5A});
        access(1'b1, 6'h08, 2'd3, 64'h1);
        chk("R9 status write refused", s_err, 1);
        access(1'b0, 6'h30, 2'd3, 0);
        chk("R9 unmapped read", {s_err, s_data}, {1'b1, 64'h0});
        access(1'b1, 6'h28, 2'd0, 64'hFF);
        chk("R9 bad size error write", error_o, 64'hC0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_status();
        t_addr(6'h10, "R4 chain", 1'b1);
        t_addr(6'h20, "R5 cmpl", 1'b0);
        t_command();
        t_error();
        t_bad();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule